// File: doc/BRIEF.md
# Bit-Serial Bus Memory Protocol Engine

This block is the device side of a small nonvolatile byte memory that hangs on an ordinary parallel processor bus but moves every bit over a single data line. The host uses plain chip-enable, output-enable and write-enable cycles. Each bus write cycle delivers one bit and each bus read cycle returns one bit. The engine has no opcodes. It recognises a handful of short read/write patterns and turns them into an engine reset, a 16-bit address load, a sequential byte read, a page load and the start of a timed commit into the array.

The array is a parameterised register file. A page buffer collects the bytes of a page load, and those bytes reach the array only when a commit finishes. A cycle counter stands in for the programming time. While a commit runs, every read returns 0, so the host can poll for completion. A write-protect input, when low, stops new commits from starting.

Bus strobes are sampled on the block clock. A bus cycle completes on the first clock edge at which its strobes are seen released, so a write bit is taken when either chip enable or write enable rises, whichever comes first.

Top module: `bitser_mem_engine`

## Requirements
- R1: A write cycle (ce_n and we_n low, oe_n high) supplies one bit, taken from io_in while the strobes are low. The bit is accepted when ce_n or we_n rises, whichever comes first. io_oe is high exactly while ce_n and oe_n are low and we_n is high. After reset io_oe is low and a read returns 1.
- R2: A read, then a write of 0, then a read resets the engine and sets the write-enable latch. The final read of that pattern, and any further reads, return 1 until an address is loaded. The address is 16 write bits sent MSB first. Only the low log2(DEPTH) bits are kept.
- R3: After the address, each group of 8 reads returns the addressed byte MSB first and then moves to the next address. After the top address (DEPTH-1) the address wraps to 0.
- R4: A read that arrives after at least one address bit and before the 16th abandons the address load. Later writes are not taken as address bits, and reads keep returning 1.
- R5: Writes after the address fill the page buffer a byte at a time, MSB first, starting at the address's column within its PAGE-byte page. A byte past the page end wraps to column 0 of the same page and overwrites what was loaded there.
- R6: After a byte-aligned page load, the pattern read, write 1, read starts a commit, provided the latch is set. Loaded bytes appear in the array at their page and column only once the commit ends. Columns that were not loaded keep their old contents.
- R7: A commit lasts COMMIT_CYC clock cycles, and every read during it returns 0. A reset pattern issued during a commit does not stop it or change its data. After it ends, idle reads return 1.
- R8: A commit pattern completed while wp_n is low starts no commit. Dropping wp_n during a running commit does not stop it.
- R9: The write-enable latch clears when a commit finishes and on any invalid sequence. A page load ended by a read in the middle of a byte leaves the engine idle, and the commit pattern that follows starts nothing.
- R10: A write of 1 after a data read ends sequential reading. The engine goes idle and later reads return 1.
- R11: After a page load, the pattern read, read, write 1, read starts no commit and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_n | input | 1 | Write protect; low blocks new commits |
| io_in | input | 1 | Data line as seen by the block during write cycles |
| io_out | output | 1 | Bit presented on the data line during read cycles |
| io_oe | output | 1 | High while the block drives the data line |

## Verification
The assertions take for granted that the strobes are synchronous to clk and that write enable and output enable are never both low while chip enable is low. They also assume each strobe stays low for at least one full clock, so that every bus cycle is seen as exactly one event. The bench meets these conditions by changing inputs only on the falling clock edge. It holds each strobe low for two clocks and leaves one idle clock between cycles. Write cycles alternate between ending on chip enable and ending on write enable, so both ways of latching a bit are exercised within the same assumptions.

// File: rtl/bsm_pkg.sv
// Shared types for the bit-serial bus memory engine.
// Assumes: one bus event per cycle end; events are decoded before sequencing.
package bsm_pkg;

    // Completed bus cycle seen in a clock cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RD   = 2'd1,
        EV_WR0  = 2'd2,
        EV_WR1  = 2'd3
    } bus_ev_e;

    // Sequencer state
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_ARM,
        ST_ADDR,
        ST_ADDR_DONE,
        ST_READ,
        ST_LOAD,
        ST_PG_END,
        ST_CM_ARM
    } eng_st_e;

    localparam int ADDR_LEN = 16;

endpackage

// File: rtl/bsm_cycle_decode.sv
// Turns sampled bus strobes into single-cycle events.
// A cycle ends on the first clock at which one of its strobes is seen high.
// Assumes: strobes are synchronous to clk and held low for at least one clock.
module bsm_cycle_decode
    import bsm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    io_in,
    output bus_ev_e ev,
    output logic    rd_now
);

    logic wr_now;
    logic wr_act_q;
    logic rd_act_q;
    logic wr_bit_q;

    assign wr_now = !ce_n && !we_n && oe_n;
    assign rd_now = !ce_n && !oe_n && we_n;

    // Track active cycles and hold the latest write bit while strobes are low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            wr_bit_q <= 1'b0;
        end else begin
            wr_act_q <= wr_now;
            rd_act_q <= rd_now;
            if (wr_now) wr_bit_q <= io_in;
        end
    end

    // Emit an event when the first strobe of an active cycle rises
    always_comb begin
        ev = EV_NONE;
        if (rd_act_q && (ce_n || oe_n))
            ev = EV_RD;
        else if (wr_act_q && (ce_n || we_n))
            ev = wr_bit_q ? EV_WR1 : EV_WR0;
    end

endmodule

// File: rtl/bsm_seq_ctrl.sv
// Pattern sequencer: recognises reset, address load, sequential read,
// page load and commit patterns from the stream of one-bit events.
// Assumes: at most one event per clock; store reports busy/commit_done.
module bsm_seq_ctrl
    import bsm_pkg::*;
#(
    parameter int AW = 9,
    parameter int PW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_ev_e          ev,
    input  logic             busy,
    input  logic             commit_done,
    input  logic             wp_n,
    output eng_st_e          st,
    output logic [AW-1:0]    addr,
    output logic [2:0]       bit_idx,
    output logic             wel,
    output logic             commit_go,
    output logic             ld_we,
    output logic [PW-1:0]    ld_col,
    output logic [7:0]       ld_byte,
    output logic [AW-PW-1:0] page,
    output logic             clr_mask
);

    eng_st_e       st_q;
    logic [3:0]    acnt_q;
    logic [AW-2:0] ashift_q;
    logic [AW-1:0] addr_q;
    logic [2:0]    bidx_q;
    logic [6:0]    dshift_q;
    logic [PW-1:0] col_q;
    logic          wel_q;
    logic          last_rd_q;

    logic          is_rd;
    logic          is_wr;
    logic          wbit;
    logic          reset_hit;
    logic [AW-1:0] full_addr;

    assign is_rd     = (ev == EV_RD);
    assign is_wr     = (ev == EV_WR0) || (ev == EV_WR1);
    assign wbit      = (ev == EV_WR1);
    // A zero written right after a read is a reset, except as an address bit
    assign reset_hit = (ev == EV_WR0) && last_rd_q && (st_q != ST_ADDR);
    // Only the low AW address bits survive in the shifter
    assign full_addr = {ashift_q, wbit};

    assign commit_go = (st_q == ST_CM_ARM) && is_rd && wel_q && wp_n && !busy;
    assign ld_we     = (st_q == ST_LOAD) && is_wr && (bidx_q == 3'd7);
    assign ld_byte   = {dshift_q, wbit};
    assign ld_col    = col_q;
    assign clr_mask  = (st_q == ST_RST_ARM) && is_rd && !busy;
    assign page      = addr_q[AW-1:PW];
    assign st        = st_q;
    assign addr      = addr_q;
    assign bit_idx   = bidx_q;
    assign wel       = wel_q;

    // Sequence state, counters and write-enable latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            acnt_q    <= '0;
            ashift_q  <= '0;
            addr_q    <= '0;
            bidx_q    <= '0;
            dshift_q  <= '0;
            col_q     <= '0;
            wel_q     <= 1'b0;
            last_rd_q <= 1'b0;
        end else begin
            if (commit_done) wel_q <= 1'b0;
            if (ev != EV_NONE) begin
                last_rd_q <= is_rd;
                if (reset_hit) begin
                    st_q <= ST_RST_ARM;
                end else begin
                    unique case (st_q)
                        ST_IDLE: ;
                        ST_RST_ARM: begin
                            if (is_rd && !busy) begin
                                st_q   <= ST_ADDR;
                                acnt_q <= '0;
                                wel_q  <= 1'b1;
                            end else begin
                                st_q <= ST_IDLE;
                                if (is_wr) wel_q <= 1'b0;
                            end
                        end
                        ST_ADDR: begin
                            if (is_wr) begin
                                ashift_q <= full_addr[AW-2:0];
                                if (acnt_q == 4'd15) begin
                                    st_q   <= ST_ADDR_DONE;
                                    addr_q <= full_addr;
                                    col_q  <= full_addr[PW-1:0];
                                    bidx_q <= '0;
                                end else begin
                                    acnt_q <= acnt_q + 4'd1;
                                end
                            end else if (acnt_q != 4'd0) begin
                                st_q  <= ST_IDLE;
                                wel_q <= 1'b0;
                            end
                        end
                        ST_ADDR_DONE: begin
                            bidx_q <= 3'd1;
                            if (is_rd) begin
                                st_q <= ST_READ;
                            end else begin
                                st_q     <= ST_LOAD;
                                dshift_q <= {dshift_q[5:0], wbit};
                            end
                        end
                        ST_READ: begin
                            if (is_rd) begin
                                bidx_q <= bidx_q + 3'd1;
                                if (bidx_q == 3'd7) addr_q <= addr_q + AW'(1);
                            end else begin
                                st_q  <= ST_IDLE;
                                wel_q <= 1'b0;
                            end
                        end
                        ST_LOAD: begin
                            if (is_wr) begin
                                dshift_q <= {dshift_q[5:0], wbit};
                                bidx_q   <= bidx_q + 3'd1;
                                if (bidx_q == 3'd7) col_q <= col_q + PW'(1);
                            end else if (bidx_q == 3'd0) begin
                                st_q <= ST_PG_END;
                            end else begin
                                st_q  <= ST_IDLE;
                                wel_q <= 1'b0;
                            end
                        end
                        ST_PG_END: begin
                            if (is_rd) begin
                                st_q  <= ST_IDLE;
                                wel_q <= 1'b0;
                            end else begin
                                st_q <= ST_CM_ARM;
                            end
                        end
                        ST_CM_ARM: begin
                            st_q <= ST_IDLE;
                            if (!commit_go) wel_q <= 1'b0;
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/bsm_store.sv
// Byte array, page buffer with per-column load mask, and commit timer.
// Loaded bytes are copied into the array when the timer expires.
// Assumes: no page-buffer writes while busy (sequencer guarantees it).
module bsm_store #(
    parameter int DEPTH      = 512,
    parameter int PAGE       = 64,
    parameter int COMMIT_CYC = 300,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE),
    localparam int TW = $clog2(COMMIT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_byte,
    input  logic             ld_we,
    input  logic [PW-1:0]    ld_col,
    input  logic [7:0]       ld_byte,
    input  logic             clr_mask,
    input  logic             commit_go,
    input  logic [AW-PW-1:0] page,
    output logic             busy,
    output logic             commit_done
);

    logic [7:0]       mem_q  [DEPTH];
    logic [7:0]       pbuf_q [PAGE];
    logic [PAGE-1:0]  pmask_q;
    logic [AW-PW-1:0] pg_q;
    logic             busy_q;
    logic [TW-1:0]    tmr_q;

    assign busy        = busy_q;
    assign commit_done = busy_q && (tmr_q == '0);
    assign rd_byte     = mem_q[rd_addr];

    // Page buffer data, one byte per completed load
    always_ff @(posedge clk) begin
        if (ld_we) pbuf_q[ld_col] <= ld_byte;
    end

    // Per-column loaded flags
    for (genvar g = 0; g < PAGE; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n || clr_mask || commit_done)
                pmask_q[g] <= 1'b0;
            else if (ld_we && (ld_col == PW'(g)))
                pmask_q[g] <= 1'b1;
        end
    end

    // Commit timer and latched page number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
            pg_q   <= '0;
        end else if (commit_go && !busy_q) begin
            busy_q <= 1'b1;
            tmr_q  <= TW'(COMMIT_CYC - 1);
            pg_q   <= page;
        end else if (busy_q) begin
            if (tmr_q == '0) busy_q <= 1'b0;
            else             tmr_q  <= tmr_q - TW'(1);
        end
    end

    // Copy loaded columns into the array when the commit ends
    always_ff @(posedge clk) begin
        if (commit_done) begin
            for (int i = 0; i < PAGE; i++) begin
                if (pmask_q[i]) mem_q[{pg_q, PW'(i)}] <= pbuf_q[i];
            end
        end
    end

endmodule

// File: rtl/bitser_mem_engine.sv
// Top: bit-serial bus memory engine. Decodes bus cycles into events,
// sequences them into memory operations and drives the single data line.
// Assumes: DEPTH and PAGE are powers of two with DEPTH >= 2*PAGE.
module bitser_mem_engine #(
    parameter int DEPTH      = 512,
    parameter int PAGE       = 64,
    parameter int COMMIT_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic wp_n,
    input  logic io_in,
    output logic io_out,
    output logic io_oe
);
    import bsm_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);

    bus_ev_e          ev_w;
    logic             rd_now_w;
    eng_st_e          st_w;
    logic [AW-1:0]    addr_w;
    logic [2:0]       bidx_w;
    logic             wel_w;
    logic             commit_go_w;
    logic             ld_we_w;
    logic [PW-1:0]    ld_col_w;
    logic [7:0]       ld_byte_w;
    logic [AW-PW-1:0] page_w;
    logic             clr_mask_w;
    logic [7:0]       rd_byte_w;
    logic             busy_w;
    logic             commit_done_w;

    bsm_cycle_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .io_in  (io_in),
        .ev     (ev_w),
        .rd_now (rd_now_w)
    );

    bsm_seq_ctrl #(.AW(AW), .PW(PW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev_w),
        .busy        (busy_w),
        .commit_done (commit_done_w),
        .wp_n        (wp_n),
        .st          (st_w),
        .addr        (addr_w),
        .bit_idx     (bidx_w),
        .wel         (wel_w),
        .commit_go   (commit_go_w),
        .ld_we       (ld_we_w),
        .ld_col      (ld_col_w),
        .ld_byte     (ld_byte_w),
        .page        (page_w),
        .clr_mask    (clr_mask_w)
    );

    bsm_store #(.DEPTH(DEPTH), .PAGE(PAGE), .COMMIT_CYC(COMMIT_CYC)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr     (addr_w),
        .rd_byte     (rd_byte_w),
        .ld_we       (ld_we_w),
        .ld_col      (ld_col_w),
        .ld_byte     (ld_byte_w),
        .clr_mask    (clr_mask_w),
        .commit_go   (commit_go_w),
        .page        (page_w),
        .busy        (busy_w),
        .commit_done (commit_done_w)
    );

    assign io_oe = rd_now_w;

    // Data-line value: busy status first, then data bit, else idle high
    always_comb begin
        if (busy_w)
            io_out = 1'b0;
        else if (st_w == ST_ADDR_DONE || st_w == ST_READ)
            io_out = rd_byte_w[3'd7 - bidx_w];
        else
            io_out = 1'b1;
    end

endmodule

// File: rtl/bsm_checker.sv
// Protocol checker bound to the engine top: commit gating, busy window,
// latch clearing and data-line status during commits.
// Assumes: synchronous active-low reset on rst_n.
module bsm_checker #(
    parameter int COMMIT_CYC = 300
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic commit_go,
    input logic wel,
    input logic wp_n,
    input logic io_oe,
    input logic io_out,
    input logic ld_we
);

    int busy_cnt;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= 0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    a_r7_busy_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && io_oe) |-> !io_out);

    a_r7_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == COMMIT_CYC));

    a_r7_start_from_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit_go));

    a_r8_wp_gates_start: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |-> wp_n);

    a_r6_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |-> (wel && !busy));

    a_r9_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    a_r5_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> !busy);

endmodule

bind bitser_mem_engine bsm_checker #(.COMMIT_CYC(COMMIT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .commit_go (commit_go_w),
    .wel       (wel_w),
    .wp_n      (wp_n),
    .io_oe     (io_oe),
    .io_out    (io_out),
    .ld_we     (ld_we_w)
);

// File: tb/bitser_mem_engine_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of array contents and the expected data line,
// checked on every bus cycle; io_oe compared against the strobes every clock.
module bitser_mem_engine_tb_top;

    localparam int DEPTH = 512;
    localparam int PAGE  = 64;
    localparam int NVC   = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1, io_in = 1'b0;
    logic io_out, io_oe;

    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0;
    bit done = 0;
    bit [7:0] ref_mem [int];

    always #4 clk = ~clk;

    bitser_mem_engine #(.DEPTH(DEPTH), .PAGE(PAGE), .COMMIT_CYC(NVC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1: the line is driven exactly while a read cycle is active
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) chk("R1 io_oe", int'(io_oe), int'(!ce_n && !oe_n && we_n));
    end

    task automatic rd(output bit b);
        @(negedge clk); ce_n = 0; oe_n = 0;
        @(negedge clk); @(negedge clk);
        b = io_out;
        ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    // Alternate which strobe rises first (R1)
    task automatic wr(bit v);
        @(negedge clk); io_in = v; ce_n = 0; we_n = 0;
        @(negedge clk); @(negedge clk);
        io_in = ~v;
        if (wr_cnt % 2 == 0) begin
            ce_n = 1; @(negedge clk); we_n = 1;
        end else begin
            we_n = 1; @(negedge clk); ce_n = 1;
        end
        wr_cnt++;
        @(negedge clk);
    endtask

    task automatic reset_seq(int exp_last, string req);
        bit b;
        rd(b); wr(0); rd(b);
        chk(req, int'(b), exp_last);
    endtask

    task automatic send_addr(int a);
        for (int i = 15; i >= 0; i--) wr(a[i]);
    endtask

    task automatic read_byte(output bit [7:0] v);
        bit b;
        v = '0;
        for (int i = 0; i < 8; i++) begin rd(b); v = {v[6:0], b}; end
    endtask

    task automatic send_byte(bit [7:0] v);
        for (int i = 7; i >= 0; i--) wr(v[i]);
    endtask

    task automatic commit_seq();
        bit b;
        rd(b); wr(1); rd(b);
    endtask

    // Full page write; model updated only if commit should start
    task automatic page_write(int a, bit [7:0] d[$], string req);
        bit b;
        int base, col;
        reset_seq(1, "R2 reset read");
        send_addr(a);
        foreach (d[i]) send_byte(d[i]);
        commit_seq();
        rd(b);
        chk(req, int'(b), wp_n ? 0 : 1);
        if (wp_n) begin
            base = (a % DEPTH) & ~(PAGE - 1);
            col  = a % PAGE;
            foreach (d[i]) ref_mem[base + (col + i) % PAGE] = d[i];
        end
    endtask

    task automatic wait_nv();
        repeat (NVC + 20) @(negedge clk);
    endtask

    task automatic expect_bytes(int a, int n, string req);
        bit [7:0] v;
        reset_seq(1, "R2 reset read");
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            read_byte(v);
            chk(req, int'(v), int'(ref_mem[(a + i) % DEPTH]));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit b;
        bit [7:0] v;
        bit [7:0] q[$];
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset io_oe", int'(io_oe), 0);
        rd(b); chk("R1 reset read", int'(b), 1);

        // R6/R7: commit with address carrying high bits (R2), status polling
        page_write(16'h7E10, '{8'h3C, 8'h5A, 8'h0F}, "R7 busy after start");
        repeat (NVC - 60) @(negedge clk);
        rd(b); chk("R7 still busy", int'(b), 0);
        wait_nv();
        rd(b); chk("R7 idle after", int'(b), 1);
        // R2: extra reads after reset return 1, upper address bits ignored
        reset_seq(1, "R2 reset read");
        rd(b); chk("R2 extra read", int'(b), 1);
        send_addr(16'h0010);
        for (int i = 0; i < 3; i++) begin
            read_byte(v); chk("R6 committed data", int'(v), int'(ref_mem[16 + i]));
        end

        // R7: reset during commit does not disturb it
        page_write(16'h0020, '{8'h81, 8'h42}, "R7 busy after start");
        reset_seq(0, "R7 reset during busy reads 0");
        wait_nv();
        expect_bytes(16'h0020, 2, "R7 data after mid-commit reset");

        // R8: write protect blocks a new commit
        wp_n = 0;
        page_write(16'h0010, '{8'hFF}, "R8 no start under protect");
        wait_nv();
        expect_bytes(16'h0010, 1, "R8 unchanged under protect");
        wp_n = 1;
        page_write(16'h0030, '{8'h99}, "R8 busy after start");
        wp_n = 0;
        wait_nv();
        wp_n = 1;
        expect_bytes(16'h0030, 1, "R8 running commit completes");

        // R9: partial byte then commit pattern starts nothing
        reset_seq(1, "R2 reset read");
        send_addr(16'h0010);
        send_byte(8'hEE);
        wr(1); wr(0); wr(1);
        commit_seq();
        rd(b); chk("R9 no commit after partial", int'(b), 1);
        expect_bytes(16'h0010, 1, "R9 array unchanged");

        // R11: read/read/write1/read after load starts nothing
        reset_seq(1, "R2 reset read");
        send_addr(16'h0010);
        send_byte(8'hEE);
        rd(b); rd(b); wr(1); rd(b);
        rd(b); chk("R11 no commit", int'(b), 1);
        expect_bytes(16'h0010, 1, "R11 array unchanged");

        // R10: write 1 after a data read ends reading (next byte MSB is 0)
        reset_seq(1, "R2 reset read");
        send_addr(16'h0010);
        read_byte(v); chk("R3 first byte", int'(v), 8'h3C);
        wr(1);
        rd(b); chk("R10 read ended", int'(b), 1);
        rd(b); chk("R10 still idle", int'(b), 1);

        // R4: read inside an address abandons it (byte at 0x10 has MSB 0)
        reset_seq(1, "R2 reset read");
        for (int i = 15; i >= 11; i--) wr(1'b0);
        rd(b); chk("R4 mid-address read", int'(b), 1);
        for (int i = 10; i >= 0; i--) wr(16'h0010 >> i);
        rd(b); chk("R4 address abandoned", int'(b), 1);

        // R3: wrap from top address to 0
        page_write(DEPTH - 1, '{8'h5A}, "R7 busy after start");
        wait_nv();
        page_write(0, '{8'hA5}, "R7 busy after start");
        wait_nv();
        expect_bytes(DEPTH - 1, 2, "R3 top wrap");

        // R5: wrap within a page from column 62
        page_write(16'h007E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R7 busy after start");
        wait_nv();
        expect_bytes(16'h007E, 2, "R5 page tail");
        expect_bytes(16'h0040, 2, "R5 wrapped head");

        // R5: 65 bytes overwrite column 0
        q.delete();
        for (int i = 0; i < PAGE + 1; i++) q.push_back(8'(i + 1));
        page_write(16'h0080, q, "R7 busy after start");
        wait_nv();
        expect_bytes(16'h0080, 3, "R5 overwrite");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule